// File: doc/BRIEF.md
# LIN/UART Status and Error Flag Registers

This block holds the status flags that a LIN/UART controller shows to software. It also holds the error-flag register behind the status register and the status interrupt. The serial engine sends it single-cycle event pulses: a transmission starts, a byte finishes, a buffered transfer completes, an error is detected. It also sends a level that shows reception is active. The block turns these inputs into sticky or live flags. Software reads the flags and clears them by writing zero.

The transmitting flag comes from a small state machine. TX_IDLE goes to TX_SINGLE when the data register is written. TX_IDLE goes to TX_BUFFER when a buffered transfer is requested, and this request wins if both start pulses arrive in the same cycle. TX_SINGLE goes back to TX_IDLE when a byte finishes and no further data is pending. TX_BUFFER goes back to TX_IDLE when the buffered transfer completes. The reset-mode level sends any state back to TX_IDLE. The error summary bit is read-only. It is the OR of the six error flags, so software clears it only by clearing those flags. The interrupt fires when the summary rises, and new errors that arrive while it is already set raise no further interrupt.

Top module: `lin_status_regs`

## Requirements
- R1: After rst_n is released, status_rd and errflag_rd both read 00h and stat_irq is low.
- R2: status_rd layout: bit 0 is the buffer-complete flag, bit 3 is the error summary, bit 4 is transmitting and bit 5 is receiving. Bits 1, 2, 6 and 7 always read 0.
- R3: While lin_rst_mode is high, both registers read 00h from the next cycle on, stat_irq stays low, the transmit state machine is in TX_IDLE, and every write and event is ignored.
- R4: A tx_buf_done pulse sets the buffer-complete flag in the next cycle. A status write (wr_sel=0) with wr_data[0]=0 clears it, and a write with wr_data[0]=1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R5: errflag_rd layout: bit 0 bit error, bit 1 overrun, bit 2 framing, bit 3 expansion bit, bit 4 ID match, bit 5 parity; bits 7:6 read 0. Each flag is set one cycle after its own event pulse.
- R6: An error-register write (wr_sel=1) clears each flag whose wr_data bit is 0 and keeps each flag whose bit is 1. If a set and a clear of the same flag arrive in the same cycle, the set wins.
- R7: The error summary (status bit 3) equals the OR of errflag_rd[5:0]. Writing to status bit 3 has no effect.
- R8: From TX_IDLE, tx_data_start enters TX_SINGLE and tx_buf_start enters TX_BUFFER, and status bit 4 is 1 from the next cycle. Start pulses are ignored while a transmission is in progress.
- R9: In TX_SINGLE, tx_byte_done with tx_more_pending=0 returns to TX_IDLE. With tx_more_pending=1 the transmission continues.
- R10: In TX_BUFFER, tx_byte_done is ignored, and tx_buf_done returns to TX_IDLE.
- R11: Status bit 5 equals rx_busy delayed by one cycle.
- R12: stat_irq is high for exactly the cycles in which the buffer-complete flag or the error summary has just changed from 0 to 1. Error events that arrive while the summary is already 1 raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lin_rst_mode | input | 1 | Controller reset-mode level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 error register |
| wr_data | input | 8 | Write data |
| tx_data_start | input | 1 | Pulse: transmit data register written |
| tx_buf_start | input | 1 | Pulse: buffered transfer requested |
| tx_byte_done | input | 1 | Pulse: one byte finished |
| tx_more_pending | input | 1 | Further single data queued |
| tx_buf_done | input | 1 | Pulse: buffered transfer complete |
| rx_busy | input | 1 | Reception in progress |
| err_parity | input | 1 | Pulse: parity error |
| err_idmatch | input | 1 | Pulse: ID match |
| err_expbit | input | 1 | Pulse: expansion bit seen |
| err_framing | input | 1 | Pulse: framing error |
| err_overrun | input | 1 | Pulse: overrun error |
| err_bit | input | 1 | Pulse: bit error |
| status_rd | output | 8 | Status register readback |
| errflag_rd | output | 8 | Error register readback |
| stat_irq | output | 1 | Status interrupt pulse |

## Verification
A wrong state inside the block shows at the ports one cycle after the event that caused it, because every flag is read straight from a register. A transmit state machine stuck in the wrong state shows up at once as a wrong bit 4. A lost or doubled interrupt shows up in the same cycle as the flag edge that should have caused it. A summary that failed to re-arm is hidden until the error flags are cleared and a new error arrives. For this reason the stimulus clears all error flags and then injects a new error.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
    localparam int STAT_W = 8;
    localparam int ERR_N  = 6;

    localparam int ST_DONE = 0;
    localparam int ST_ESUM = 3;
    localparam int ST_TXB  = 4;
    localparam int ST_RXB  = 5;

    localparam int EF_BIT = 0;
    localparam int EF_OVR = 1;
    localparam int EF_FRM = 2;
    localparam int EF_EXP = 3;
    localparam int EF_IDM = 4;
    localparam int EF_PAR = 5;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_SINGLE = 2'd1,
        TX_BUFFER = 2'd2
    } tx_state_e;
endpackage

// File: rtl/lin_w0c_bit.sv
module lin_w0c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_rst,
    input  logic set_ev,
    input  logic clr_req,
    output logic flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (hold_rst)
            flag_d = 1'b0;
        else if (set_ev)
            flag_d = 1'b1;
        else if (clr_req)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= flag_d;
    end

    assert_set_wins_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && !hold_rst) |=> flag_q);
endmodule

// File: rtl/lin_err_flags.sv
module lin_err_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_rst,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] set_ev,
    output logic [N-1:0] flags_q,
    output logic         any_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        lin_w0c_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_rst(hold_rst),
            .set_ev  (set_ev[i]),
            .clr_req (wr_en && !wr_bits[i]),
            .flag_q  (flags_q[i])
        );
    end

    assign any_q = |flags_q;

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev && !hold_rst) |=> ((flags_q & $past(set_ev)) == $past(set_ev)));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_rst && !wr_en) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/lin_tx_fsm.sv
module lin_tx_fsm
    import lin_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_rst,
    input  logic data_start,
    input  logic buf_start,
    input  logic byte_done,
    input  logic more_pending,
    input  logic buf_done,
    output logic busy
);
    tx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (hold_rst) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (buf_start)
                        state_d = TX_BUFFER;
                    else if (data_start)
                        state_d = TX_SINGLE;
                end
                TX_SINGLE: begin
                    if (byte_done && !more_pending)
                        state_d = TX_IDLE;
                end
                TX_BUFFER: begin
                    if (buf_done)
                        state_d = TX_IDLE;
                end
                default: state_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TX_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        busy = (state_q != TX_IDLE);
    end

    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TX_IDLE) && (data_start || buf_start) && !hold_rst) |=> busy);

    assert_buf_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TX_BUFFER) && byte_done && !buf_done && !hold_rst) |=> busy);
endmodule

// File: rtl/lin_irq_gen.sv
module lin_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic done_flag,
    input  logic err_sum,
    output logic irq
);
    logic done_prev_q;
    logic sum_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_prev_q <= 1'b0;
            sum_prev_q  <= 1'b0;
        end else begin
            done_prev_q <= done_flag;
            sum_prev_q  <= err_sum;
        end
    end

    assign irq = (done_flag && !done_prev_q) || (err_sum && !sum_prev_q);
endmodule

// File: rtl/lin_status_regs.sv
module lin_status_regs
    import lin_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lin_rst_mode,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        tx_data_start,
    input  logic        tx_buf_start,
    input  logic        tx_byte_done,
    input  logic        tx_more_pending,
    input  logic        tx_buf_done,
    input  logic        rx_busy,
    input  logic        err_parity,
    input  logic        err_idmatch,
    input  logic        err_expbit,
    input  logic        err_framing,
    input  logic        err_overrun,
    input  logic        err_bit,
    output logic [7:0]  status_rd,
    output logic [7:0]  errflag_rd,
    output logic        stat_irq
);
    logic [ERR_N-1:0] err_ev;
    logic [ERR_N-1:0] err_q;
    logic             err_any;
    logic             done_q;
    logic             tx_busy;
    logic             rx_q;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[7:ERR_N];

    always_comb begin
        err_ev         = '0;
        err_ev[EF_BIT] = err_bit;
        err_ev[EF_OVR] = err_overrun;
        err_ev[EF_FRM] = err_framing;
        err_ev[EF_EXP] = err_expbit;
        err_ev[EF_IDM] = err_idmatch;
        err_ev[EF_PAR] = err_parity;
    end

    lin_w0c_bit u_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_rst(lin_rst_mode),
        .set_ev  (tx_buf_done),
        .clr_req (wr_en && !wr_sel && !wr_data[ST_DONE]),
        .flag_q  (done_q)
    );

    lin_err_flags #(.N(ERR_N)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_rst(lin_rst_mode),
        .wr_en   (wr_en && wr_sel),
        .wr_bits (wr_data[ERR_N-1:0]),
        .set_ev  (err_ev),
        .flags_q (err_q),
        .any_q   (err_any)
    );

    lin_tx_fsm u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_rst    (lin_rst_mode),
        .data_start  (tx_data_start),
        .buf_start   (tx_buf_start),
        .byte_done   (tx_byte_done),
        .more_pending(tx_more_pending),
        .buf_done    (tx_buf_done),
        .busy        (tx_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= 1'b0;
        else
            rx_q <= rx_busy && !lin_rst_mode;
    end

    lin_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_flag(done_q),
        .err_sum  (err_any),
        .irq      (stat_irq)
    );

    always_comb begin
        status_rd          = '0;
        status_rd[ST_DONE] = done_q;
        status_rd[ST_ESUM] = err_any;
        status_rd[ST_TXB]  = tx_busy;
        status_rd[ST_RXB]  = rx_q;
        errflag_rd         = '0;
        errflag_rd[ERR_N-1:0] = err_q;
    end

    assert_rm_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lin_rst_mode |=> (status_rd == 8'h00 && errflag_rd == 8'h00 && !stat_irq));

    assert_buf_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_buf_done && !lin_rst_mode && !status_rd[ST_DONE]) |=> stat_irq);

    assert_no_rearm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((errflag_rd != 8'h00) && (|err_ev) && !lin_rst_mode && !tx_buf_done) |=> !stat_irq);

    assert_rx_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_rst_mode) |=> (status_rd[ST_RXB] == $past(rx_busy)));
endmodule

// File: tb/lin_status_regs_tb.sv
module lin_status_regs_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lin_rst_mode = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic tx_data_start = 0, tx_buf_start = 0, tx_byte_done = 0;
    logic tx_more_pending = 0, tx_buf_done = 0, rx_busy = 0;
    logic err_parity = 0, err_idmatch = 0, err_expbit = 0;
    logic err_framing = 0, err_overrun = 0, err_bit = 0;
    logic [7:0] status_rd, errflag_rd;
    logic stat_irq;

    int checks = 0;
    int fails = 0;
    string phase = "R1";
    bit model_on = 0;

    // reference model state
    bit m_done, m_rx, m_irq;
    int m_tx;            // 0 idle, 1 single, 2 buffer
    bit [5:0] m_err;

    always #2 clk = ~clk;

    lin_status_regs u_dut (
        .clk(clk), .rst_n(rst_n), .lin_rst_mode(lin_rst_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tx_data_start(tx_data_start), .tx_buf_start(tx_buf_start),
        .tx_byte_done(tx_byte_done), .tx_more_pending(tx_more_pending),
        .tx_buf_done(tx_buf_done), .rx_busy(rx_busy),
        .err_parity(err_parity), .err_idmatch(err_idmatch), .err_expbit(err_expbit),
        .err_framing(err_framing), .err_overrun(err_overrun), .err_bit(err_bit),
        .status_rd(status_rd), .errflag_rd(errflag_rd), .stat_irq(stat_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_done = 0; m_rx = 0; m_irq = 0; m_tx = 0; m_err = '0;
        end else if (lin_rst_mode) begin
            m_irq = (m_done == 0 && 0) ;
            m_done = 0; m_rx = 0; m_tx = 0; m_err = '0; m_irq = 0;
        end else begin
            bit nd;
            bit [5:0] ne, ev;
            ev = {err_parity, err_idmatch, err_expbit, err_framing, err_overrun, err_bit};
            nd = m_done;
            if (tx_buf_done) nd = 1;
            else if (wr_en && !wr_sel && !wr_data[0]) nd = 0;
            for (int i = 0; i < 6; i++) begin
                ne[i] = m_err[i];
                if (ev[i]) ne[i] = 1;
                else if (wr_en && wr_sel && !wr_data[i]) ne[i] = 0;
            end
            case (m_tx)
                0: if (tx_buf_start) m_tx = 2; else if (tx_data_start) m_tx = 1;
                1: if (tx_byte_done && !tx_more_pending) m_tx = 0;
                default: if (tx_buf_done) m_tx = 0;
            endcase
            m_irq = (nd && !m_done) || ((ne != 0) && (m_err == 0));
            m_done = nd; m_err = ne; m_rx = rx_busy;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (phase %s) at %0t: actual %0h expected %0h", req, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            chk("R2 reserved", int'(status_rd & 8'hC6), 0);
            chk("R4 done", int'(status_rd[0]), int'(m_done));
            chk("R7 summary", int'(status_rd[3]), int'(m_err != 0));
            chk("R8 transmitting", int'(status_rd[4]), int'(m_tx != 0));
            chk("R11 receiving", int'(status_rd[5]), int'(m_rx));
            chk("R5 R6 errflags", int'(errflag_rd), int'({2'b00, m_err}));
            chk("R12 irq", int'(stat_irq), int'(m_irq));
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1: reset values
        chk("R1 status", int'(status_rd), 0);
        chk("R1 errflags", int'(errflag_rd), 0);
        chk("R1 irq", int'(stat_irq), 0);
        model_on = 1;

        phase = "R11";
        rx_busy = 1; tick(3); rx_busy = 0; tick(2);

        phase = "R9";
        tx_data_start = 1; tick(); tx_data_start = 0; tick(2);
        tx_buf_start = 1; tick(); tx_buf_start = 0;          // ignored while busy (R8)
        tx_more_pending = 1; tx_byte_done = 1; tick(); tx_byte_done = 0; tick();
        tx_more_pending = 0; tx_byte_done = 1; tick(); tx_byte_done = 0; tick(2);

        phase = "R10";
        tx_buf_start = 1; tx_data_start = 1; tick(); tx_buf_start = 0; tx_data_start = 0;
        tx_byte_done = 1; tick(); tx_byte_done = 0; tick();
        tx_buf_done = 1; tick(); tx_buf_done = 0; tick(2);

        phase = "R4";
        wr(0, 8'hFF); tick();
        wr(0, 8'hF7); tick();                                // bit3 write no effect
        wr(0, 8'hFE); tick();
        tx_buf_done = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h00; tick();
        tx_buf_done = 0; wr_en = 0; tick();
        wr(0, 8'hFE); tick();

        phase = "R12";
        err_parity = 1; tick(); err_parity = 0; tick();
        err_overrun = 1; tick(); err_overrun = 0;
        err_idmatch = 1; err_expbit = 1; tick(); err_idmatch = 0; err_expbit = 0; tick();

        phase = "R6";
        wr(1, 8'hDF); tick();                                // clear parity only
        err_framing = 1; wr_en = 1; wr_sel = 1; wr_data = 8'hC0; tick();
        err_framing = 0; wr_en = 0; tick();
        wr(1, 8'h00); tick(2);
        err_bit = 1; tick(); err_bit = 0; tick();            // re-arm after full clear
        wr(0, 8'hF7); tick();                                // R7: summary not writable
        wr(1, 8'h00); tick();

        phase = "R3";
        tx_buf_done = 1; err_framing = 1; tick(); tx_buf_done = 0; err_framing = 0;
        tx_data_start = 1; tick(); tx_data_start = 0; rx_busy = 1; tick();
        lin_rst_mode = 1; tick(2);
        wr(1, 8'hFF); err_bit = 1; tx_buf_done = 1; tx_data_start = 1; tick();
        err_bit = 0; tx_buf_done = 0; tx_data_start = 0; tick(2);
        lin_rst_mode = 0; rx_busy = 0; tick(3);

        model_on = 0;
        tick();
        finish_run();
    end
endmodule